// File: doc/BRIEF.md
# MSI Coherent L1 Cache Controller

This block is a small blocking L1 cache with one outstanding miss. It tracks an MSI permission for each line of a direct-mapped array of word-sized lines. The processor side accepts load and store requests through a valid/ready handshake. Each accepted request produces a one-cycle response pulse. A load response carries the word. A store response carries zero as an acknowledgement.

Toward the parent, the block sends messages on an upward channel and receives messages on a downward channel. Both channels use valid/ready. The upward channel carries fill requests and downgrade replies. The downward channel carries fill grants and downgrade demands. A miss moves through a fixed sequence of stages: it evicts the indexed line if that line holds a copy, sends a fill request, waits for the grant, and then answers the processor. Downgrade demands from the parent are handled alongside the miss sequence, except in the final response stage.

Encodings used on both channels:
- Permission field: I = 2'b00, S = 2'b01, M = 2'b10. The order is M > S > I.
- Kind bit: 1 marks a request (a fill request going up, a downgrade demand coming down); 0 marks a reply (a downgrade reply or voluntary eviction going up, a fill grant coming down).
- Address layout: the low log2(LINES) bits select the line, and the remaining upper bits are the tag.

Top module: `msi_l1_ctrl`

## Requirements
- R1: After reset, every line is I, `req_ready_o` is 1, and `c2p_valid_o` and `rsp_valid_o` are 0. The first access to any address therefore misses.
- R2: A load whose line holds the tag in S or M is a hit. `rsp_valid_o` pulses in the cycle after acceptance with the stored word, and no upward message is sent.
- R3: A store whose line holds the tag in M is a hit. It writes the word and pulses `rsp_valid_o` with data 0 in the cycle after acceptance, and no upward message is sent.
- R4: A load miss sends an upward request (kind 1) for the miss address asking for S (2'b01). A store miss, including a store to a line held only in S, asks for M (2'b10).
- R5: When the indexed line is not I at miss time, a voluntary reply (kind 0) with permission I and the victim's address is sent before the fill request. It carries data (`c2p_has_data_o` = 1) only if the victim was M. The line then becomes I.
- R6: A grant (kind 0) received while waiting installs the granted permission, the new tag and the word. A load then returns the granted word. A store writes its own data into the line and returns 0.
- R7: A downgrade demand to permission y for a line held in a higher permission is answered with a reply (kind 0) carrying y. The reply includes data only if the line was M, and the line drops to y.
- R8: A downgrade demand whose target is not below the line's current permission (an absent tag counts as I) is consumed with no reply and no change to the line.
- R9: While the miss sequence is in its response stage, a downgrade demand is not consumed (`p2c_ready_o` = 0).
- R10: A downgrade demand for the address currently awaiting a fill is consumed with no reply.
- R11: While a miss is in progress, `req_ready_o` is 0, so at most one request is outstanding.
- R12: The miss stages occur strictly in the order ready, start (evict), fill request, fill wait, response, ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Processor request valid |
| req_ready_o | output | 1 | Processor request accepted this cycle |
| req_store_i | input | 1 | 1 = store, 0 = load |
| req_addr_i | input | ADDR_W | Word address |
| req_data_i | input | DATA_W | Store data |
| rsp_valid_o | output | 1 | One-cycle response pulse |
| rsp_data_o | output | DATA_W | Load word, or 0 for a store |
| c2p_valid_o | output | 1 | Upward message valid |
| c2p_ready_i | input | 1 | Parent takes upward message |
| c2p_is_req_o | output | 1 | 1 = fill request, 0 = downgrade reply |
| c2p_addr_o | output | ADDR_W | Message address |
| c2p_state_o | output | 2 | Requested or resulting permission |
| c2p_has_data_o | output | 1 | Data field is meaningful |
| c2p_data_o | output | DATA_W | Dirty word |
| p2c_valid_i | input | 1 | Downward message valid |
| p2c_ready_o | output | 1 | Controller takes downward message |
| p2c_is_req_i | input | 1 | 1 = downgrade demand, 0 = fill grant |
| p2c_addr_i | input | ADDR_W | Message address |
| p2c_state_i | input | 2 | Target or granted permission |
| p2c_data_i | input | DATA_W | Fill word |

## Verification
The assertions take several things for granted about the parent:
- A fill grant arrives only while the controller waits for one, and it is meant for the pending miss address.
- A grant names S or M.
- The parent never sends a demand that raises a permission.

The stimulus keeps within these rules. The bench plays the parent: it answers each fill request with exactly one grant for that address, and it sends downgrade demands only at the points where each scenario places them. Inputs are held stable between handshakes, so every valid/ready pair completes on a single clock edge.

// File: rtl/msi_pkg.sv
package msi_pkg;
  typedef enum logic [1:0] {
    ST_I = 2'b00,
    ST_S = 2'b01,
    ST_M = 2'b10
  } msi_e;

  typedef enum logic [2:0] {
    MS_READY,
    MS_START,
    MS_FILL_REQ,
    MS_FILL_WAIT,
    MS_RESP
  } miss_e;
endpackage

// File: rtl/msi_line_array.sv
module msi_line_array
  import msi_pkg::*;
#(
  parameter int LINES  = 4,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  rd_a_idx_i,
  output msi_e              rd_a_st_o,
  output logic [TAG_W-1:0]  rd_a_tag_o,
  output logic [DATA_W-1:0] rd_a_data_o,
  input  logic [IDX_W-1:0]  rd_b_idx_i,
  output msi_e              rd_b_st_o,
  output logic [TAG_W-1:0]  rd_b_tag_o,
  output logic [DATA_W-1:0] rd_b_data_o,
  input  logic              wr_st_we_i,
  input  msi_e              wr_st_i,
  input  logic [TAG_W-1:0]  wr_tag_i,
  input  logic              wr_data_we_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              dn_we_i,
  input  logic [IDX_W-1:0]  dn_idx_i,
  input  msi_e              dn_st_i
);
  msi_e              st_q   [LINES];
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < LINES; i++) st_q[i] <= ST_I;
    end else if (wr_st_we_i) begin
      st_q[rd_a_idx_i] <= wr_st_i;
    end else if (dn_we_i) begin
      st_q[dn_idx_i] <= dn_st_i;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_st_we_i)   tag_q[rd_a_idx_i]  <= wr_tag_i;
    if (wr_data_we_i) data_q[rd_a_idx_i] <= wr_data_i;
  end

  assign rd_a_st_o   = st_q[rd_a_idx_i];
  assign rd_a_tag_o  = tag_q[rd_a_idx_i];
  assign rd_a_data_o = data_q[rd_a_idx_i];
  assign rd_b_st_o   = st_q[rd_b_idx_i];
  assign rd_b_tag_o  = tag_q[rd_b_idx_i];
  assign rd_b_data_o = data_q[rd_b_idx_i];

  // R7: miss-side and downgrade-side writes never collide
  a_r7_single_writer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((wr_st_we_i || wr_data_we_i) && dn_we_i));
endmodule

// File: rtl/msi_dng_unit.sv
module msi_dng_unit
  import msi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 2,
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              req_valid_i,
  input  logic              allow_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  msi_e              tgt_i,
  input  msi_e              line_st_i,
  input  logic [TAG_W-1:0]  line_tag_i,
  input  logic [DATA_W-1:0] line_data_i,
  input  logic              busy_i,
  input  logic [ADDR_W-1:0] busy_addr_i,
  input  logic              c2p_ready_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic              ready_o,
  output logic              reply_o,
  output logic              reply_has_data_o,
  output logic [DATA_W-1:0] reply_data_o,
  output logic              we_o
);
  logic present;
  msi_e cur;

  assign idx_o   = addr_i[IDX_W-1:0];
  // line awaiting fill counts as already downgraded
  assign present = (line_st_i != ST_I) && (line_tag_i == addr_i[ADDR_W-1:IDX_W])
                   && !(busy_i && (busy_addr_i == addr_i));
  assign cur     = present ? line_st_i : ST_I;

  assign reply_o          = req_valid_i && allow_i && (cur > tgt_i);
  assign ready_o          = allow_i && (!reply_o || c2p_ready_i);
  assign we_o             = reply_o && c2p_ready_i;
  assign reply_has_data_o = (cur == ST_M);
  assign reply_data_o     = line_data_i;
endmodule

// File: rtl/msi_miss_fsm.sv
module msi_miss_fsm
  import msi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 2,
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_store_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_data_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_data_o,
  input  logic              dng_busy_i,
  output logic [IDX_W-1:0]  rd_idx_o,
  input  msi_e              rd_st_i,
  input  logic [TAG_W-1:0]  rd_tag_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              wr_st_we_o,
  output msi_e              wr_st_o,
  output logic [TAG_W-1:0]  wr_tag_o,
  output logic              wr_data_we_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              c2p_valid_o,
  input  logic              c2p_ready_i,
  output logic              c2p_is_req_o,
  output logic [ADDR_W-1:0] c2p_addr_o,
  output msi_e              c2p_state_o,
  output logic              c2p_has_data_o,
  output logic [DATA_W-1:0] c2p_data_o,
  input  logic              fill_valid_i,
  output logic              fill_ready_o,
  input  msi_e              fill_state_i,
  input  logic [DATA_W-1:0] fill_data_i,
  output miss_e             state_o,
  output logic [ADDR_W-1:0] miss_addr_o
);
  miss_e             state_q, state_d;
  logic              miss_store_q;
  logic [ADDR_W-1:0] miss_addr_q;
  logic [DATA_W-1:0] miss_data_q;
  logic              rsp_valid_q, rsp_valid_d;
  logic [DATA_W-1:0] rsp_data_q, rsp_data_d;
  logic [ADDR_W-1:0] cur_addr;
  logic [TAG_W-1:0]  cur_tag;
  logic              accept, hit_ok;

  assign cur_addr    = (state_q == MS_READY) ? req_addr_i : miss_addr_q;
  assign rd_idx_o    = cur_addr[IDX_W-1:0];
  assign cur_tag     = cur_addr[ADDR_W-1:IDX_W];
  assign req_ready_o = (state_q == MS_READY) && !dng_busy_i;
  assign accept      = req_valid_i && req_ready_o;
  assign hit_ok      = (rd_st_i != ST_I) && (rd_tag_i == cur_tag)
                       && (!req_store_i || rd_st_i == ST_M);

  always_comb begin
    state_d        = state_q;
    rsp_valid_d    = 1'b0;
    rsp_data_d     = '0;
    wr_st_we_o     = 1'b0;
    wr_st_o        = ST_I;
    wr_tag_o       = cur_tag;
    wr_data_we_o   = 1'b0;
    wr_data_o      = req_data_i;
    c2p_valid_o    = 1'b0;
    c2p_is_req_o   = 1'b0;
    c2p_addr_o     = miss_addr_q;
    c2p_state_o    = ST_I;
    c2p_has_data_o = 1'b0;
    c2p_data_o     = rd_data_i;
    fill_ready_o   = 1'b0;
    unique case (state_q)
      MS_READY: if (accept) begin
        if (hit_ok) begin
          rsp_valid_d = 1'b1;
          if (req_store_i) wr_data_we_o = 1'b1;
          else             rsp_data_d   = rd_data_i;
        end else begin
          state_d = MS_START;
        end
      end
      MS_START: begin
        if (rd_st_i != ST_I) begin
          c2p_valid_o    = 1'b1;
          c2p_addr_o     = {rd_tag_i, rd_idx_o};
          c2p_has_data_o = (rd_st_i == ST_M);
          if (c2p_ready_i) begin
            wr_st_we_o = 1'b1;
            state_d    = MS_FILL_REQ;
          end
        end else begin
          state_d = MS_FILL_REQ;
        end
      end
      MS_FILL_REQ: begin
        c2p_valid_o  = 1'b1;
        c2p_is_req_o = 1'b1;
        c2p_state_o  = miss_store_q ? ST_M : ST_S;
        c2p_data_o   = '0;
        if (c2p_ready_i) state_d = MS_FILL_WAIT;
      end
      MS_FILL_WAIT: begin
        fill_ready_o = 1'b1;
        if (fill_valid_i) begin
          wr_st_we_o   = 1'b1;
          wr_st_o      = fill_state_i;
          wr_data_we_o = 1'b1;
          wr_data_o    = fill_data_i;
          state_d      = MS_RESP;
        end
      end
      MS_RESP: begin
        rsp_valid_d = 1'b1;
        if (miss_store_q) begin
          wr_data_we_o = 1'b1;
          wr_data_o    = miss_data_q;
        end else begin
          rsp_data_d = rd_data_i;
        end
        state_d = MS_READY;
      end
      default: state_d = MS_READY;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= MS_READY;
      rsp_valid_q  <= 1'b0;
      rsp_data_q   <= '0;
      miss_store_q <= 1'b0;
      miss_addr_q  <= '0;
      miss_data_q  <= '0;
    end else begin
      state_q     <= state_d;
      rsp_valid_q <= rsp_valid_d;
      rsp_data_q  <= rsp_data_d;
      if (accept && !hit_ok) begin
        miss_store_q <= req_store_i;
        miss_addr_q  <= req_addr_i;
        miss_data_q  <= req_data_i;
      end
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_data_o  = rsp_data_q;
  assign state_o     = state_q;
  assign miss_addr_o = miss_addr_q;

  // R11: no new request while a miss is open
  a_r11_one_outstanding: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != MS_READY) |-> !req_ready_o);
  // R12: stage order
  a_r12_start_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == MS_START) |=> (state_q == MS_START || state_q == MS_FILL_REQ));
  a_r12_req_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == MS_FILL_REQ) |=> (state_q == MS_FILL_REQ || state_q == MS_FILL_WAIT));
  a_r12_wait_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == MS_FILL_WAIT) |=> (state_q == MS_FILL_WAIT || state_q == MS_RESP));
  // R6: response stage always answers the processor
  a_r6_resp_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == MS_RESP) |=> (rsp_valid_o && state_q == MS_READY));
  // R5: indexed line is empty before the fill request leaves
  a_r5_evicted_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == MS_FILL_REQ) |-> (rd_st_i == ST_I));
endmodule

// File: rtl/msi_l1_ctrl.sv
module msi_l1_ctrl
  import msi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int LINES  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_store_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_data_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_data_o,
  output logic              c2p_valid_o,
  input  logic              c2p_ready_i,
  output logic              c2p_is_req_o,
  output logic [ADDR_W-1:0] c2p_addr_o,
  output logic [1:0]        c2p_state_o,
  output logic              c2p_has_data_o,
  output logic [DATA_W-1:0] c2p_data_o,
  input  logic              p2c_valid_i,
  output logic              p2c_ready_o,
  input  logic              p2c_is_req_i,
  input  logic [ADDR_W-1:0] p2c_addr_i,
  input  logic [1:0]        p2c_state_i,
  input  logic [DATA_W-1:0] p2c_data_i
);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0]  a_idx, b_idx;
  msi_e              a_st, b_st;
  logic [TAG_W-1:0]  a_tag, b_tag;
  logic [DATA_W-1:0] a_data, b_data;
  logic              wr_st_we, wr_data_we;
  msi_e              wr_st;
  logic [TAG_W-1:0]  wr_tag;
  logic [DATA_W-1:0] wr_data;

  logic              f_valid, f_is_req, f_has_data, fill_ready;
  logic [ADDR_W-1:0] f_addr, miss_addr;
  msi_e              f_state;
  logic [DATA_W-1:0] f_data;
  miss_e             fsm_state;

  logic              dng_req, dng_allow, dng_ready, dng_reply, dng_has_data, dng_we;
  logic [DATA_W-1:0] dng_data;
  logic              fill_busy;

  assign dng_req   = p2c_valid_i && p2c_is_req_i;
  assign dng_allow = (fsm_state != MS_RESP) && !f_valid;
  assign fill_busy = (fsm_state == MS_FILL_REQ) || (fsm_state == MS_FILL_WAIT);

  msi_line_array #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_array (
    .clk_i, .rst_ni,
    .rd_a_idx_i(a_idx), .rd_a_st_o(a_st), .rd_a_tag_o(a_tag), .rd_a_data_o(a_data),
    .rd_b_idx_i(b_idx), .rd_b_st_o(b_st), .rd_b_tag_o(b_tag), .rd_b_data_o(b_data),
    .wr_st_we_i(wr_st_we), .wr_st_i(wr_st), .wr_tag_i(wr_tag),
    .wr_data_we_i(wr_data_we), .wr_data_i(wr_data),
    .dn_we_i(dng_we), .dn_idx_i(b_idx), .dn_st_i(msi_e'(p2c_state_i))
  );

  msi_miss_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_fsm (
    .clk_i, .rst_ni,
    .req_valid_i, .req_ready_o, .req_store_i, .req_addr_i, .req_data_i,
    .rsp_valid_o, .rsp_data_o,
    .dng_busy_i(dng_req),
    .rd_idx_o(a_idx), .rd_st_i(a_st), .rd_tag_i(a_tag), .rd_data_i(a_data),
    .wr_st_we_o(wr_st_we), .wr_st_o(wr_st), .wr_tag_o(wr_tag),
    .wr_data_we_o(wr_data_we), .wr_data_o(wr_data),
    .c2p_valid_o(f_valid), .c2p_ready_i, .c2p_is_req_o(f_is_req),
    .c2p_addr_o(f_addr), .c2p_state_o(f_state), .c2p_has_data_o(f_has_data),
    .c2p_data_o(f_data),
    .fill_valid_i(p2c_valid_i && !p2c_is_req_i), .fill_ready_o(fill_ready),
    .fill_state_i(msi_e'(p2c_state_i)), .fill_data_i(p2c_data_i),
    .state_o(fsm_state), .miss_addr_o(miss_addr)
  );

  msi_dng_unit #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_dng (
    .req_valid_i(dng_req), .allow_i(dng_allow), .addr_i(p2c_addr_i),
    .tgt_i(msi_e'(p2c_state_i)),
    .line_st_i(b_st), .line_tag_i(b_tag), .line_data_i(b_data),
    .busy_i(fill_busy), .busy_addr_i(miss_addr), .c2p_ready_i,
    .idx_o(b_idx), .ready_o(dng_ready), .reply_o(dng_reply),
    .reply_has_data_o(dng_has_data), .reply_data_o(dng_data), .we_o(dng_we)
  );

  // miss sequence owns the upward channel when it needs it
  always_comb begin
    if (f_valid) begin
      c2p_valid_o    = 1'b1;
      c2p_is_req_o   = f_is_req;
      c2p_addr_o     = f_addr;
      c2p_state_o    = f_state;
      c2p_has_data_o = f_has_data;
      c2p_data_o     = f_data;
    end else begin
      c2p_valid_o    = dng_reply;
      c2p_is_req_o   = 1'b0;
      c2p_addr_o     = p2c_addr_i;
      c2p_state_o    = p2c_state_i;
      c2p_has_data_o = dng_has_data;
      c2p_data_o     = dng_data;
    end
  end

  assign p2c_ready_o = p2c_is_req_i ? dng_ready : fill_ready;

  // R9: demands wait out the response stage
  a_r9_hold_in_resp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fsm_state == MS_RESP && dng_req) |-> !p2c_ready_o);
  // R10: demand for the address being filled draws no reply
  a_r10_inflight_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fsm_state == MS_FILL_WAIT && dng_req && p2c_addr_i == miss_addr) |-> !c2p_valid_o);
  // R8: a reply never raises permission
  a_r8_reply_not_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c2p_valid_o && !c2p_is_req_o) |-> (c2p_state_o != 2'b10));
endmodule

// File: tb/msi_l1_ctrl_tb.sv
module msi_l1_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam logic [1:0] SI = 2'b00, SS = 2'b01, SM = 2'b10;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          req_valid = 0, req_store = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic          req_ready, rsp_valid;
  logic [DW-1:0] rsp_data;
  logic          c2p_valid, c2p_ready = 0, c2p_is_req, c2p_has_data;
  logic [AW-1:0] c2p_addr;
  logic [1:0]    c2p_state;
  logic [DW-1:0] c2p_data;
  logic          p2c_valid = 0, p2c_ready, p2c_is_req = 0;
  logic [AW-1:0] p2c_addr = '0;
  logic [1:0]    p2c_state = '0;
  logic [DW-1:0] p2c_data = '0;

  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  msi_l1_ctrl #(.ADDR_W(AW), .DATA_W(DW), .LINES(4)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_store_i(req_store),
    .req_addr_i(req_addr), .req_data_i(req_data),
    .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data),
    .c2p_valid_o(c2p_valid), .c2p_ready_i(c2p_ready), .c2p_is_req_o(c2p_is_req),
    .c2p_addr_o(c2p_addr), .c2p_state_o(c2p_state), .c2p_has_data_o(c2p_has_data),
    .c2p_data_o(c2p_data),
    .p2c_valid_i(p2c_valid), .p2c_ready_o(p2c_ready), .p2c_is_req_i(p2c_is_req),
    .p2c_addr_i(p2c_addr), .p2c_state_i(p2c_state), .p2c_data_i(p2c_data)
  );

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic proc(input bit st, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    req_valid = 1; req_store = st; req_addr = a; req_data = d;
    @(posedge clk);
    #1 req_valid = 0;
  endtask

  task automatic wait_rsp(input logic [DW-1:0] exp, input bit quiet, input string tag);
    bit seen = 0, up = 0;
    for (int i = 0; i < 20 && !seen; i++) begin
      @(negedge clk); #1;
      if (c2p_valid) up = 1;
      if (rsp_valid) seen = 1;
    end
    chk(seen, {tag, " response pulse"}, seen, 1);
    chk(rsp_data == exp, {tag, " response data"}, rsp_data, exp);
    if (quiet) chk(!up, {tag, " no upward traffic"}, up, 0);
  endtask

  task automatic exp_c2p(input bit isreq, input logic [AW-1:0] a, input logic [1:0] s,
                         input bit hd, input logic [DW-1:0] d, input string tag);
    bit seen = 0;
    for (int i = 0; i < 20 && !seen; i++) begin
      @(negedge clk); #1;
      if (c2p_valid) seen = 1;
    end
    chk(seen, {tag, " upward valid"}, seen, 1);
    chk(c2p_is_req == isreq, {tag, " kind"}, c2p_is_req, isreq);
    chk(c2p_addr == a, {tag, " addr"}, c2p_addr, a);
    chk(c2p_state == s, {tag, " permission"}, c2p_state, s);
    chk(c2p_has_data == hd, {tag, " has_data"}, c2p_has_data, hd);
    if (hd) chk(c2p_data == d, {tag, " data"}, c2p_data, d);
    c2p_ready = 1;
    @(posedge clk);
    #1 c2p_ready = 0;
  endtask

  task automatic fill(input logic [1:0] s, input logic [DW-1:0] d, input string tag);
    @(negedge clk);
    p2c_valid = 1; p2c_is_req = 0; p2c_state = s; p2c_data = d;
    #1 chk(p2c_ready == 1, {tag, " grant taken"}, p2c_ready, 1);
    @(posedge clk);
    #1 p2c_valid = 0;
  endtask

  task automatic dng(input logic [AW-1:0] a, input logic [1:0] y, input bit reply,
                     input bit hd, input logic [DW-1:0] d, input string tag);
    @(negedge clk);
    p2c_valid = 1; p2c_is_req = 1; p2c_addr = a; p2c_state = y;
    #1;
    chk(c2p_valid == reply, {tag, " reply present"}, c2p_valid, reply);
    if (reply) begin
      chk(c2p_is_req == 0, {tag, " reply kind"}, c2p_is_req, 0);
      chk(c2p_state == y, {tag, " reply permission"}, c2p_state, y);
      chk(c2p_has_data == hd, {tag, " reply has_data"}, c2p_has_data, hd);
      if (hd) chk(c2p_data == d, {tag, " reply data"}, c2p_data, d);
      c2p_ready = 1;
    end
    #1 chk(p2c_ready == 1, {tag, " demand taken"}, p2c_ready, 1);
    @(posedge clk);
    #1 p2c_valid = 0; c2p_ready = 0;
  endtask

  task automatic t_reset();
    @(negedge clk); #1;
    chk(req_ready == 1, "R1 req_ready", req_ready, 1);
    chk(c2p_valid == 0, "R1 c2p_valid", c2p_valid, 0);
    chk(rsp_valid == 0, "R1 rsp_valid", rsp_valid, 0);
  endtask

  task automatic t_load_miss_cold();
    proc(0, 8'h05, '0);
    exp_c2p(1, 8'h05, SS, 0, '0, "R4 load fill request, R1 no eviction");
    @(negedge clk); #1 chk(req_ready == 0, "R11 busy during miss", req_ready, 0);
    fill(SS, 32'hA1, "R6");
    wait_rsp(32'hA1, 0, "R6 load fill");
  endtask

  task automatic t_hits();
    proc(0, 8'h05, '0);
    wait_rsp(32'hA1, 1, "R2 load hit S");
    proc(1, 8'h05, 32'hB2);
    exp_c2p(0, 8'h05, SI, 0, '0, "R5 evict shared line");
    exp_c2p(1, 8'h05, SM, 0, '0, "R4 store upgrade asks M");
    fill(SM, 32'hA1, "R6");
    wait_rsp(32'h0, 0, "R6 store ack");
    proc(0, 8'h05, '0);
    wait_rsp(32'hB2, 1, "R6 store data merged, R2 hit M");
    proc(1, 8'h05, 32'hC3);
    wait_rsp(32'h0, 1, "R3 store hit ack");
    proc(0, 8'h05, '0);
    wait_rsp(32'hC3, 1, "R3 store hit data");
  endtask

  task automatic t_evict_dirty();
    proc(0, 8'h09, '0);
    exp_c2p(0, 8'h05, SI, 1, 32'hC3, "R5 R12 dirty eviction first");
    exp_c2p(1, 8'h09, SS, 0, '0, "R12 fill request after eviction");
    fill(SS, 32'hD4, "R6");
    wait_rsp(32'hD4, 0, "R6 load after eviction");
  endtask

  task automatic t_downgrades();
    dng(8'h09, SI, 1, 0, '0, "R7 S to I");
    proc(0, 8'h09, '0);
    exp_c2p(1, 8'h09, SS, 0, '0, "R7 line now I");
    fill(SS, 32'hE5, "R6");
    wait_rsp(32'hE5, 0, "R6 refill");
    dng(8'h09, SS, 0, 0, '0, "R8 S to S dropped");
    dng(8'h0D, SI, 0, 0, '0, "R8 absent tag dropped");
    proc(0, 8'h09, '0);
    wait_rsp(32'hE5, 1, "R8 line unchanged");
    proc(1, 8'h02, 32'hF6);
    exp_c2p(1, 8'h02, SM, 0, '0, "R4 store miss asks M");
    fill(SM, 32'h0, "R6");
    wait_rsp(32'h0, 0, "R6 store miss ack");
    dng(8'h02, SS, 1, 1, 32'hF6, "R7 M to S with data");
    proc(0, 8'h02, '0);
    wait_rsp(32'hF6, 1, "R7 still readable in S");
    proc(1, 8'h02, 32'h11);
    exp_c2p(0, 8'h02, SI, 0, '0, "R7 line dropped to S, not M");
    exp_c2p(1, 8'h02, SM, 0, '0, "R4 upgrade request");
    fill(SM, 32'hF6, "R6");
    wait_rsp(32'h0, 0, "R6 upgrade ack");
  endtask

  task automatic t_inflight();
    proc(0, 8'h03, '0);
    exp_c2p(1, 8'h03, SS, 0, '0, "R4 cold load");
    dng(8'h03, SI, 0, 0, '0, "R10 demand on in-flight address");
    fill(SS, 32'h77, "R6");
    wait_rsp(32'h77, 0, "R10 fill after dropped demand");
  endtask

  task automatic t_resp_block();
    proc(0, 8'h07, '0);
    exp_c2p(0, 8'h03, SI, 0, '0, "R5 clean eviction");
    exp_c2p(1, 8'h07, SS, 0, '0, "R4 load request");
    @(negedge clk);
    p2c_valid = 1; p2c_is_req = 0; p2c_state = SM; p2c_data = 32'h88;
    @(posedge clk);
    #1 p2c_is_req = 1; p2c_addr = 8'h07; p2c_state = SI;
    @(negedge clk); #1;
    chk(p2c_ready == 0, "R9 demand held in response stage", p2c_ready, 0);
    chk(c2p_valid == 0, "R9 no reply in response stage", c2p_valid, 0);
    @(negedge clk); #1;
    chk(rsp_valid == 1, "R6 response pulse", rsp_valid, 1);
    chk(rsp_data == 32'h88, "R6 response data", rsp_data, 32'h88);
    chk(c2p_valid == 1, "R7 reply after response", c2p_valid, 1);
    chk(c2p_has_data == 1, "R7 reply data from M grant", c2p_has_data, 1);
    chk(c2p_data == 32'h88, "R7 reply word", c2p_data, 32'h88);
    c2p_ready = 1;
    @(posedge clk);
    #1 p2c_valid = 0; c2p_ready = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_load_miss_cold();
    t_hits();
    t_evict_dirty();
    t_downgrades();
    t_inflight();
    t_resp_block();
    repeat (3) @(posedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule